// File: doc/BRIEF.md
# Receive Byte Queue with Break Insertion

This block is the receive-side holding queue of a serial port. A deserializer hands over each received byte with a one-cycle strobe. Software, through the port's data register, takes the oldest byte with a pop strobe. The queue holds four bytes. It drives the two status flags software polls: one says data is waiting and one says the queue is full. It also tells the deserializer whether it may deliver another byte.

A detected line break arrives on its own strobe. It raises a sticky delta-break flag and places a zero byte into the queue, so software sees where in the data stream the break happened. The break byte is never lost. When the queue is already full, it takes the place of the newest byte. A receiver-reset command flushes the queue in a single cycle. A separate clear strobe, driven by the break-change reset command, drops the delta-break flag.

The occupancy count is brought out as a port so that integration logic and test benches can observe it.

Top module: `rxq_break_fifo`

## Requirements
- R1: Bytes leave the queue in arrival order. At most four are held at once.
- R2: Every accepted byte or break sets `rx_ready`. An insertion that brings the occupancy to four sets `fifo_full`.
- R3: A pop while the queue is empty presents 0x00 on `pop_data`, and the occupancy and flags stay as they were.
- R4: A pop on a non-empty queue clears `fifo_full`. It also clears `rx_ready` when it removes the last byte.
- R5: `rx_accept` is high exactly when `rx_enable` is high and `fifo_full` is low. A data push while `rx_accept` is low is dropped.
- R6: A break strobe sets `brk_flag` and inserts 0x00 whether or not the receiver is enabled. A data push in the same cycle is dropped.
- R7: A break on a full queue overwrites the newest byte with 0x00, and the occupancy stays four.
- R8: `flush` sets the occupancy to zero and clears `rx_ready` and `fifo_full`. It overrides a push, pop or break insertion in the same cycle.
- R9: A push and a pop in the same cycle on a queue that is neither empty nor full leave the occupancy unchanged and keep the byte order.
- R10: `brk_clr` clears `brk_flag`. When a break strobe arrives in the same cycle, the flag stays set.
- R11: After synchronous reset the occupancy is zero and `rx_ready`, `fifo_full` and `brk_flag` are low.
- R12: `occupancy` always reports the number of bytes held, from 0 to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_enable | input | 1 | Receiver enabled |
| push_valid | input | 1 | Deserializer byte strobe |
| push_data | input | 8 | Received byte |
| break_evt | input | 1 | Line-break detected strobe |
| pop | input | 1 | Read oldest byte |
| flush | input | 1 | Receiver reset: empty the queue |
| brk_clr | input | 1 | Clear delta-break flag |
| pop_data | output | 8 | Oldest byte, 0x00 when empty |
| rx_ready | output | 1 | At least one byte held |
| fifo_full | output | 1 | Four bytes held |
| rx_accept | output | 1 | Deserializer may push |
| brk_flag | output | 1 | Delta-break flag |
| occupancy | output | 3 | Bytes held |

## Verification
The checker evaluates these properties on every cycle:
- flag consistency: `fifo_full` implies `rx_ready`, and `rx_accept` is low while full;
- the occupancy bound;
- that a flush empties the queue on the next cycle;
- that a break sets the flag;
- that an idle pop on an empty queue leaves the queue unchanged.

Only the bench scenarios can show byte ordering and data values. This covers:
- overwrite of the newest entry by a break byte;
- simultaneous push and pop;
- the 0x00 returned by an empty pop.

These are checked against a scoreboard of expected popped bytes.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int unsigned RXQ_BYTE_W = 8;

    typedef logic [RXQ_BYTE_W-1:0] rxq_byte_t;

    typedef enum logic [1:0] {
        INS_NONE  = 2'd0,
        INS_DATA  = 2'd1,
        INS_BRK   = 2'd2
    } rxq_ins_e;

    typedef struct packed {
        logic     flush;
        logic     pop;
        rxq_ins_e ins;
    } rxq_op_t;

    function automatic rxq_byte_t ins_byte(rxq_ins_e kind, rxq_byte_t data);
        return (kind == INS_BRK) ? '0 : data;
    endfunction
endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned CW = $clog2(DEPTH + 1),
    localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rx_enable,
    input  logic          push_valid,
    input  logic          break_evt,
    input  logic          pop,
    input  logic          flush,
    input  logic          brk_clr,
    output rxq_op_t       op,
    output logic [IW-1:0] wr_idx,
    output logic [CW-1:0] count,
    output logic          rdy_q,
    output logic          full_q,
    output logic          accept,
    output logic          brk_q
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [CW-1:0] after_pop;
    logic [CW-1:0] count_nxt;

    assign accept = rx_enable & ~full_q;

    always_comb begin
        op.flush = flush;
        op.pop   = pop & (count != '0);
        if (break_evt)
            op.ins = INS_BRK;
        else if (push_valid && accept)
            op.ins = INS_DATA;
        else
            op.ins = INS_NONE;

        after_pop = count - CW'(op.pop);
        wr_idx    = (after_pop == FULL_CNT) ? IW'(DEPTH - 1) : IW'(after_pop);

        if (op.flush)
            count_nxt = '0;
        else if (op.ins != INS_NONE && after_pop != FULL_CNT)
            count_nxt = after_pop + CW'(1);
        else
            count_nxt = after_pop;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count  <= '0;
            rdy_q  <= 1'b0;
            full_q <= 1'b0;
            brk_q  <= 1'b0;
        end else begin
            count  <= count_nxt;
            rdy_q  <= (count_nxt != '0);
            full_q <= (count_nxt == FULL_CNT);
            if (break_evt)
                brk_q <= 1'b1;
            else if (brk_clr)
                brk_q <= 1'b0;
        end
    end
endmodule

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  rxq_op_t       op,
    input  logic [IW-1:0] wr_idx,
    input  rxq_byte_t     wr_data,
    output rxq_byte_t     head
);
    rxq_byte_t slot [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        rxq_byte_t shifted;
        rxq_byte_t nxt;

        if (i < DEPTH - 1) begin : g_mid
            always_comb shifted = op.pop ? slot[i+1] : slot[i];
        end else begin : g_last
            always_comb shifted = slot[i];
        end

        always_comb begin
            nxt = shifted;
            if (op.ins != INS_NONE && wr_idx == IW'(i))
                nxt = wr_data;
        end

        always_ff @(posedge clk) begin
            if (!op.flush)
                slot[i] <= nxt;
        end
    end

    assign head = slot[0];
endmodule

// File: rtl/rxq_break_fifo.sv
module rxq_break_fifo
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned CW = $clog2(DEPTH + 1),
    localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rx_enable,
    input  logic            push_valid,
    input  logic [7:0]      push_data,
    input  logic            break_evt,
    input  logic            pop,
    input  logic            flush,
    input  logic            brk_clr,
    output logic [7:0]      pop_data,
    output logic            rx_ready,
    output logic            fifo_full,
    output logic            rx_accept,
    output logic            brk_flag,
    output logic [CW-1:0]   occupancy
);
    rxq_op_t        op;
    logic [IW-1:0]  wr_idx;
    rxq_byte_t      head;

    rxq_ctrl #(.DEPTH(DEPTH)) ctrl_i (
        .clk        (clk),
        .rst        (rst),
        .rx_enable  (rx_enable),
        .push_valid (push_valid),
        .break_evt  (break_evt),
        .pop        (pop),
        .flush      (flush),
        .brk_clr    (brk_clr),
        .op         (op),
        .wr_idx     (wr_idx),
        .count      (occupancy),
        .rdy_q      (rx_ready),
        .full_q     (fifo_full),
        .accept     (rx_accept),
        .brk_q      (brk_flag)
    );

    rxq_store #(.DEPTH(DEPTH)) store_i (
        .clk     (clk),
        .op      (op),
        .wr_idx  (wr_idx),
        .wr_data (ins_byte(op.ins, push_data)),
        .head    (head)
    );

    assign pop_data = (occupancy != '0) ? head : '0;
endmodule

// File: rtl/rxq_break_fifo_chk.sv
module rxq_break_fifo_chk #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned CW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          push_valid,
    input logic          break_evt,
    input logic          pop,
    input logic          flush,
    input logic          rx_ready,
    input logic          fifo_full,
    input logic          rx_accept,
    input logic          brk_flag,
    input logic [CW-1:0] occupancy
);
    // R2: a full queue always reports data waiting
    assert_full_has_data_R2: assert property (@(posedge clk) disable iff (rst)
        fifo_full |-> rx_ready);

    // R5: deserializer is held off while full
    assert_no_accept_when_full_R5: assert property (@(posedge clk) disable iff (rst)
        fifo_full |-> !rx_accept);

    // R12: occupancy never exceeds depth
    assert_no_overflow_R12: assert property (@(posedge clk) disable iff (rst)
        occupancy <= CW'(DEPTH));

    // R8: flush empties the queue on the next cycle
    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (rst)
        flush |=> (occupancy == '0 && !rx_ready && !fifo_full));

    // R6: a break strobe raises the delta-break flag
    assert_break_sets_flag_R6: assert property (@(posedge clk) disable iff (rst)
        break_evt |=> brk_flag);

    // R3: idle pop on empty queue changes nothing
    assert_empty_pop_stable_R3: assert property (@(posedge clk) disable iff (rst)
        (pop && occupancy == '0 && !push_valid && !break_evt && !flush)
        |=> (occupancy == '0 && !rx_ready && !fifo_full));

    // R7: break on a full queue keeps it full
    assert_break_full_stays_R7: assert property (@(posedge clk) disable iff (rst)
        (break_evt && fifo_full && !pop && !flush) |=> fifo_full);
endmodule

bind rxq_break_fifo rxq_break_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .push_valid (push_valid),
    .break_evt  (break_evt),
    .pop        (pop),
    .flush      (flush),
    .rx_ready   (rx_ready),
    .fifo_full  (fifo_full),
    .rx_accept  (rx_accept),
    .brk_flag   (brk_flag),
    .occupancy  (occupancy)
);

// File: tb/rxq_break_fifo_tb_top.sv
module rxq_break_fifo_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       rx_enable, push_valid, break_evt, pop, flush, brk_clr;
    logic [7:0] push_data;
    logic [7:0] pop_data;
    logic       rx_ready, fifo_full, rx_accept, brk_flag;
    logic [2:0] occupancy;

    int checks = 0;
    int fails  = 0;

    // reference model
    logic [7:0] mq[$];
    logic [7:0] sb_q[$];
    string      sb_tag[$];
    logic       m_brk = 1'b0;
    event       pop_ev;

    always #4 clk = ~clk;

    rxq_break_fifo dut_i (
        .clk(clk), .rst(rst), .rx_enable(rx_enable), .push_valid(push_valid),
        .push_data(push_data), .break_evt(break_evt), .pop(pop), .flush(flush),
        .brk_clr(brk_clr), .pop_data(pop_data), .rx_ready(rx_ready),
        .fifo_full(fifo_full), .rx_accept(rx_accept), .brk_flag(brk_flag),
        .occupancy(occupancy)
    );

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // monitor: compares popped bytes against the scoreboard
    initial begin
        forever begin
            @(pop_ev);
            if (sb_q.size() > 0) begin
                logic [7:0] e;
                string      t;
                e = sb_q.pop_front();
                t = sb_tag.pop_front();
                chk(t, "pop_data", pop_data, e);
            end
        end
    end

    task automatic check_state(string tag);
        chk(tag, "occupancy", occupancy, mq.size());
        chk(tag, "rx_ready", rx_ready, mq.size() != 0);
        chk(tag, "fifo_full", fifo_full, mq.size() == 4);
        chk(tag, "rx_accept", rx_accept, rx_enable && mq.size() != 4);
        chk(tag, "brk_flag", brk_flag, m_brk);
    endtask

    task automatic step(string tag, bit en, bit psh, logic [7:0] d, bit brk,
                        bit pp, bit fl, bit clr);
        bit ins;
        logic [7:0] v;
        @(negedge clk);
        rx_enable = en; push_valid = psh; push_data = d; break_evt = brk;
        pop = pp; flush = fl; brk_clr = clr;
        #1;
        if (pp) begin
            sb_q.push_back(mq.size() > 0 ? mq[0] : 8'h00);
            sb_tag.push_back(tag);
            -> pop_ev;
        end
        #1;
        // model update
        ins = brk || (psh && en && mq.size() != 4);
        v   = brk ? 8'h00 : d;
        if (fl) mq.delete();
        else begin
            if (pp && mq.size() > 0) void'(mq.pop_front());
            if (ins) begin
                if (mq.size() == 4) mq[3] = v;
                else mq.push_back(v);
            end
        end
        if (brk) m_brk = 1'b1;
        else if (clr) m_brk = 1'b0;
        @(posedge clk);
        #1;
        check_state(tag);
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1;
        rx_enable = 0; push_valid = 0; push_data = 0; break_evt = 0;
        pop = 0; flush = 0; brk_clr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1 check_state("R11");

        // R2 / R12: fill queue
        step("R2", 1, 1, 8'h11, 0, 0, 0, 0);
        step("R2", 1, 1, 8'h22, 0, 0, 0, 0);
        step("R2", 1, 1, 8'h33, 0, 0, 0, 0);
        step("R12", 1, 1, 8'h44, 0, 0, 0, 0);
        // R5: push while full dropped
        step("R5", 1, 1, 8'h55, 0, 0, 0, 0);
        // R4: pop clears full; R1 order
        step("R4", 1, 0, 8'h00, 0, 1, 0, 0);
        // R9: push+pop same cycle at count 3
        step("R9", 1, 1, 8'h66, 0, 1, 0, 0);
        step("R1", 1, 0, 8'h00, 0, 1, 0, 0);
        step("R1", 1, 0, 8'h00, 0, 1, 0, 0);
        step("R4", 1, 0, 8'h00, 0, 1, 0, 0);
        // R3: pop empty
        step("R3", 1, 0, 8'h00, 0, 1, 0, 0);
        // R5: disabled push dropped
        step("R5", 0, 1, 8'h77, 0, 0, 0, 0);
        // R6: break while disabled, push same cycle dropped
        step("R6", 0, 0, 8'h00, 1, 0, 0, 0);
        step("R6", 1, 1, 8'h88, 1, 0, 0, 0);
        // R10: clear flag, then clear with break
        step("R10", 1, 0, 8'h00, 0, 0, 0, 1);
        step("R10", 1, 0, 8'h00, 1, 0, 0, 1);
        // R7: fill and break on full
        step("R7", 1, 1, 8'h99, 0, 0, 0, 0);
        step("R7", 1, 0, 8'h00, 1, 0, 0, 0);
        for (int i = 0; i < 4; i++) step("R7", 1, 0, 8'h00, 0, 1, 0, 0);
        // R9: push+pop with bytes A,B
        step("R9", 1, 1, 8'hA1, 0, 0, 0, 0);
        step("R9", 1, 1, 8'hB2, 0, 0, 0, 0);
        step("R9", 1, 1, 8'hC3, 0, 1, 0, 0);
        step("R1", 1, 0, 8'h00, 0, 1, 0, 0);
        // R8: flush with push and pop
        step("R8", 1, 1, 8'hD4, 0, 1, 1, 0);
        step("R8", 1, 1, 8'hE5, 0, 0, 0, 0);
        step("R8", 1, 0, 8'h00, 1, 0, 1, 0);
        step("R3", 1, 0, 8'h00, 0, 1, 0, 0);
        step("R10", 1, 0, 8'h00, 0, 0, 0, 1);

        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule